// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier with Truncation

This block multiplies two IEEE-754 binary32 words and returns their binary32 product one clock after a valid strobe. Each operand is split into sign, biased exponent and 23-bit fraction. The hidden leading one is restored, giving a 24-bit significand, and the two significands are multiplied into a 48-bit product. The exponents are added and the bias is removed. The product is renormalized with at most one right shift, and then cut back to 23 fraction bits by plain truncation (round toward zero).

Results that fall outside the normal exponent range are not wrapped. A product that is too large saturates to a signed infinity and raises an overflow flag. A product that is too small flushes to a signed zero and raises an underflow flag. An operand equal to zero gives a signed zero with no flag. The block is intended for datapaths that hold only finite, normal operands and zeros, and that can accept round-toward-zero accuracy.

Top module: `fp32_mul_trunc`

## Requirements
- R1: When `in_valid` is high at a rising edge, `result`, `overflow` and `underflow` for those operands appear after that edge, and `out_valid` is high for exactly that following cycle.
- R2: Bit 31 of `result` is the XOR of bit 31 of the two operands, for every class of result, zero results included.
- R3: If the biased result exponent (ea + eb − 127, plus 1 when a normalizing shift occurs) is 255 or more, `overflow` is 1 and `result` is sign, exponent 0xFF (bits 30:23) and fraction 0 (bits 22:0).
- R4: If that biased exponent is 0 or less, `underflow` is 1 and `result` has bits 30:0 all zero.
- R5: If either operand has bits 30:0 all zero, `result` bits 30:0 are zero and both flags are 0, even where the exponent sum would otherwise underflow.
- R6: When the significand product lies in [1,2) (product bit 47 clear), the result exponent is ea + eb − 127 and the fraction is product bits 45:23.
- R7: When the significand product lies in [2,4) (product bit 47 set), the exponent is incremented by one and the fraction is product bits 46:24. This increment can cause an overflow, and it can prevent an underflow.
- R8: The product bits below the kept fraction are discarded with no rounding, even when they are more than half of one unit in the last place.
- R9: A synchronous active-high reset clears `out_valid`, `result`, `overflow` and `underflow` to 0.
- R10: While `in_valid` is low, `out_valid` is 0 in the following cycle, and `result` and the flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| op_a | input | 32 | First binary32 operand |
| op_b | input | 32 | Second binary32 operand |
| out_valid | output | 1 | Result registers updated in the previous edge |
| result | output | 32 | Binary32 product, truncated |
| overflow | output | 1 | Product saturated to infinity |
| underflow | output | 1 | Product flushed to zero |

## Verification
The assertions take for granted that every operand is either a zero or a finite normal number, with an exponent field between 1 and 254. Infinities, NaNs and subnormal encodings are outside the block's contract, and the properties make no claim about them. The stimulus table and the directed tests therefore use only zeros and normal values. The boundary cases are reached through extreme but legal exponents, for example 2^127 multiplied by 2, and 2^-126 multiplied by 0.5.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int PROD_W  = 2 * SIG_W;
    localparam int SUM_W   = EXP_W + 2;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_word_t;

    typedef struct packed {
        logic              sign;
        logic              is_zero;
        logic [EXP_W-1:0]  exp;
        logic [SIG_W-1:0]  sig;
    } fp_unpacked_t;

    typedef enum logic [1:0] {
        CLS_NORMAL = 2'd0,
        CLS_ZERO   = 2'd1,
        CLS_OVF    = 2'd2,
        CLS_UNF    = 2'd3
    } res_class_t;

    function automatic fp_word_t make_word(input logic s,
                                           input logic [EXP_W-1:0] e,
                                           input logic [FRAC_W-1:0] f);
        fp_word_t w;
        w.sign = s;
        w.exp  = e;
        w.frac = f;
        return w;
    endfunction
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
    import fpm_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fp_unpacked_t      up
);
    fp_word_t w;
    assign w = fp_word_t'(word);

    always_comb begin
        up.sign    = w.sign;
        up.exp     = w.exp;
        up.is_zero = (w.exp == '0) && (w.frac == '0);
        up.sig     = {1'b1, w.frac};
    end
endmodule

// File: rtl/fpm_sig_norm.sv
module fpm_sig_norm
    import fpm_pkg::*;
(
    input  logic [SIG_W-1:0]  sig_a,
    input  logic [SIG_W-1:0]  sig_b,
    output logic [FRAC_W-1:0] frac,
    output logic              shift
);
    logic [PROD_W-1:0] prod;

    always_comb begin
        prod  = PROD_W'(sig_a) * PROD_W'(sig_b);
        shift = prod[PROD_W-1];
        if (shift)
            frac = prod[PROD_W-2 -: FRAC_W];
        else
            frac = prod[PROD_W-3 -: FRAC_W];
    end
endmodule

// File: rtl/fpm_exp_pack.sv
module fpm_exp_pack
    import fpm_pkg::*;
(
    input  fp_unpacked_t      a,
    input  fp_unpacked_t      b,
    input  logic [FRAC_W-1:0] frac,
    input  logic              shift,
    output fp_word_t          res,
    output res_class_t        cls
);
    localparam logic [SUM_W-1:0] OVF_LIMIT = SUM_W'(EXP_MAX + BIAS);
    localparam logic [SUM_W-1:0] UNF_LIMIT = SUM_W'(BIAS);

    logic             sign;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sign = a.sign ^ b.sign;
        sum  = {2'b00, a.exp} + {2'b00, b.exp} + SUM_W'(shift);
        if (a.is_zero || b.is_zero) begin
            cls = CLS_ZERO;
            res = make_word(sign, '0, '0);
        end else if (sum >= OVF_LIMIT) begin
            cls = CLS_OVF;
            res = make_word(sign, EXP_W'(EXP_MAX), '0);
        end else if (sum <= UNF_LIMIT) begin
            cls = CLS_UNF;
            res = make_word(sign, '0, '0);
        end else begin
            cls = CLS_NORMAL;
            res = make_word(sign, EXP_W'(sum - UNF_LIMIT), frac);
        end
    end
endmodule

// File: rtl/fp32_mul_trunc.sv
module fp32_mul_trunc
    import fpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic              overflow,
    output logic              underflow
);
    localparam int N_OPS = 2;

    logic [WORD_W-1:0] ops [N_OPS];
    fp_unpacked_t      up  [N_OPS];
    logic [FRAC_W-1:0] frac;
    logic              shift;
    fp_word_t          res;
    res_class_t        cls;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar i = 0; i < N_OPS; i++) begin : g_unpack
        fpm_unpack u_unpack (
            .word (ops[i]),
            .up   (up[i])
        );
    end

    fpm_sig_norm u_sig (
        .sig_a (up[0].sig),
        .sig_b (up[1].sig),
        .frac  (frac),
        .shift (shift)
    );

    fpm_exp_pack u_pack (
        .a     (up[0]),
        .b     (up[1]),
        .frac  (frac),
        .shift (shift),
        .res   (res),
        .cls   (cls)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= res;
                overflow  <= (cls == CLS_OVF);
                underflow <= (cls == CLS_UNF);
            end
        end
    end

    // R1: valid follows the input strobe by one cycle
    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2: sign of result is the XOR of operand signs
    assert_sign_xor_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (result[WORD_W-1] == $past(op_a[WORD_W-1] ^ op_b[WORD_W-1])));

    // R3: overflow gives a signed infinity
    assert_ovf_inf_R3: assert property (@(posedge clk) disable iff (rst)
        overflow |-> (result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

    // R4: underflow gives a signed zero
    assert_unf_zero_R4: assert property (@(posedge clk) disable iff (rst)
        underflow |-> (result[WORD_W-2:0] == '0));

    // R3 and R4 cannot both hold
    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(overflow && underflow));

    // R5: a zero operand gives zero with no flags
    assert_zero_operand_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op_a[WORD_W-2:0] == '0 || op_b[WORD_W-2:0] == '0)) |=>
        (result[WORD_W-2:0] == '0 && !overflow && !underflow));

    // R10: idle cycles hold the result and drop the valid strobe
    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result) && $stable(overflow) && $stable(underflow)));
endmodule

// File: tb/fp32_mul_trunc_tb.sv
module fp32_mul_trunc_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        overflow;
    logic        underflow;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    fp32_mul_trunc u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .out_valid (out_valid),
        .result    (result),
        .overflow  (overflow),
        .underflow (underflow)
    );

    // {a, b, expected result, ovf, unf, requirement number}
    localparam int NV = 20;
    localparam logic [101:0] VEC [0:NV-1] = '{
        {32'h3F800000, 32'h3F800000, 32'h3F800000, 1'b0, 1'b0, 4'd6},  // R6 1*1
        {32'h40000000, 32'h40400000, 32'h40C00000, 1'b0, 1'b0, 4'd6},  // R6 2*3
        {32'h3FC00000, 32'h3FC00000, 32'h40100000, 1'b0, 1'b0, 4'd7},  // R7 1.5*1.5
        {32'hC0000000, 32'h40400000, 32'hC0C00000, 1'b0, 1'b0, 4'd2},  // R2 -2*3
        {32'hBFC00000, 32'hBFC00000, 32'h40100000, 1'b0, 1'b0, 4'd2},  // R2 neg*neg
        {32'h3FC00001, 32'h3FC00001, 32'h40100001, 1'b0, 1'b0, 4'd8},  // R8 over half dropped
        {32'h3FFFFFFF, 32'h3FFFFFFF, 32'h407FFFFE, 1'b0, 1'b0, 4'd8},  // R8 max significands
        {32'h7F000000, 32'h40000000, 32'h7F800000, 1'b1, 1'b0, 4'd3},  // R3 overflow
        {32'hFF000000, 32'h40000000, 32'hFF800000, 1'b1, 1'b0, 4'd3},  // R3 negative overflow
        {32'h7F000000, 32'h3F800000, 32'h7F000000, 1'b0, 1'b0, 4'd3},  // R3 exponent 254 kept
        {32'h7F400000, 32'h3FC00000, 32'h7F800000, 1'b1, 1'b0, 4'd7},  // R7 shift overflows
        {32'h00800000, 32'h3F000000, 32'h00000000, 1'b0, 1'b1, 4'd4},  // R4 underflow
        {32'h80800000, 32'h3F000000, 32'h80000000, 1'b0, 1'b1, 4'd4},  // R4 negative zero
        {32'h00800000, 32'h3F800000, 32'h00800000, 1'b0, 1'b0, 4'd4},  // R4 exponent 1 kept
        {32'h00C00000, 32'h3F400000, 32'h00900000, 1'b0, 1'b0, 4'd7},  // R7 shift rescues
        {32'h00000000, 32'h7F000000, 32'h00000000, 1'b0, 1'b0, 4'd5},  // R5 zero*huge
        {32'h80000000, 32'h3F800000, 32'h80000000, 1'b0, 1'b0, 4'd5},  // R5 -0*1
        {32'h00000000, 32'hC0000000, 32'h80000000, 1'b0, 1'b0, 4'd5},  // R5 0*-2
        {32'h00000000, 32'h00800000, 32'h00000000, 1'b0, 1'b0, 4'd5},  // R5 no false underflow
        {32'h3F800001, 32'h3F800001, 32'h3F800002, 1'b0, 1'b0, 4'd6}   // R6 low bits
    };

    task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_a = a; op_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", {out_valid, result, overflow, underflow}, 35'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [101:0] v;
            v = VEC[i];
            apply(v[101:70], v[69:38]);
            check($sformatf("R%0d", v[3:0]), {out_valid, result, overflow, underflow},
                  {1'b1, v[37:6], v[5], v[4]});
        end

        // R10: idle cycle holds result, valid drops
        apply(32'h40000000, 32'h40400000);
        op_a = 32'h7F000000; op_b = 32'h40000000;
        @(negedge clk);
        check("R10", {out_valid, result, overflow, underflow}, {1'b0, 32'h40C00000, 2'b00});

        // R1: back-to-back strobes, each result one cycle later
        @(negedge clk);
        op_a = 32'h3FC00000; op_b = 32'h3FC00000; in_valid = 1'b1;
        @(negedge clk);
        check("R1", {out_valid, result, overflow, underflow}, {1'b1, 32'h40100000, 2'b00});
        op_a = 32'h7F000000; op_b = 32'h40000000;
        @(negedge clk);
        check("R1", {out_valid, result, overflow, underflow}, {1'b1, 32'h7F800000, 2'b10});
        in_valid = 1'b0;
        @(negedge clk);
        check("R1", {34'd0, out_valid}, 35'd0);

        // R9: reset after activity clears everything
        apply(32'h00800000, 32'h3F000000);
        rst = 1'b1;
        @(negedge clk);
        check("R9", {out_valid, result, overflow, underflow}, 35'd0);
        rst = 1'b0;

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule